// File: doc/BRIEF.md
# Byte-Enabled Single-Port RAM with Write-Through Output

This block is a clocked single-port memory whose word is split into lanes. Every lane is either a plain 8-bit byte or a 9-bit slot that holds 8 data bits plus a parity bit. A write updates only the lanes whose bit in the byte-enable mask is high. All other lanes keep what they held.

The write enable, address, write data and byte-enable mask are all captured on the rising clock edge. The read port is combinational from that captured state. In a cycle with no write, it shows the stored word at the captured address. In the cycle that follows a captured write, the output passes the new data straight through on the enabled lanes. On the masked lanes it shows one of two things, chosen by a build parameter: the contents still held at that address, or a fixed filler pattern.

A synchronous reset clears only the captured write strobe. The mask register, the address register and the stored words are never cleared.

Top module: `ber_ram`

## Requirements
- R1: `wr_en`, `addr`, `wdata` and `byte_en` are sampled on the rising edge of `clk`. During the following cycle, `rdata` is a function of those sampled values and the stored words only.
- R2: Lane mapping: `byte_en[i]` governs `wdata`/`rdata` bits `[i*LANE_W +: LANE_W]`. Bit 0 of the mask is the least significant lane and the top mask bit is the most significant lane.
- R3: `LANE_W` is 8 or 9. With 9, one mask bit covers all nine bits of its lane, including the parity bit at lane bit 8.
- R4: A sampled write with a lane enabled stores that lane's data, and it is returned by later reads of that address.
- R5: A lane whose mask bit is 0 during a sampled write keeps its stored contents unchanged. This includes the case of a mask of all zeros.
- R6: In the cycle after a sampled write, the enabled lanes of `rdata` show the newly written data.
- R7: With `POLICY` = `MASK_KEEP`, the masked lanes of `rdata` in that cycle show the current stored contents of the address.
- R8: With `POLICY` = `MASK_FILL`, the masked lanes of `rdata` in that cycle show `FILL_PAT[LANE_W-1:0]`.
- R9: When the sampled `wr_en` is 0, `byte_en` has no effect and `rdata` equals the stored word at the sampled address.
- R10: While `rst` is high at a rising edge, no write is performed, even if `wr_en` is high. The output then shows the stored word. Stored contents are not cleared by reset.
- R11: A mask of all ones writes the full word, so that `wr_en` alone decides whether a write happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the write strobe |
| wr_en | input | 1 | Write request |
| addr | input | AW | Word address |
| wdata | input | LANES*LANE_W | Write data, lane-packed |
| byte_en | input | LANES | Active-high per-lane write mask |
| rdata | output | LANES*LANE_W | Read / write-through data |

## Verification
The bench builds two copies side by side, driven by the same stimulus:
- The first has two 9-bit lanes and the keep policy. It exercises parity bits and the stored-contents view of masked lanes.
- The second has four 8-bit lanes and the fill policy (filler 8'h5A). It shows the filler on up to three masked lanes at once and exercises a wider mask.

Both copies use a 16-word depth. This lets a preload pass make every location known, and lets random addresses revisit the same locations often.

// File: rtl/ber_pkg.sv
`timescale 1ns/1ps
package ber_pkg;

    // What a masked lane shows on the read port during a write cycle
    typedef enum logic {
        MASK_KEEP = 1'b0,   // stored contents of the addressed word
        MASK_FILL = 1'b1    // constant filler pattern
    } mask_pol_e;

    function automatic int unsigned word_width(input int unsigned lanes,
                                               input int unsigned lane_w);
        return lanes * lane_w;
    endfunction

endpackage

// File: rtl/ber_req_reg.sv
`timescale 1ns/1ps
module ber_req_reg #(
    parameter int unsigned LANES = 2,
    parameter int unsigned DW    = 18,
    parameter int unsigned AW    = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic [LANES-1:0] byte_en,
    output logic             we_q,
    output logic [AW-1:0]    addr_q,
    output logic [DW-1:0]    data_q,
    output logic [LANES-1:0] be_q
);

    typedef struct packed {
        logic [AW-1:0]    addr;
        logic [DW-1:0]    data;
        logic [LANES-1:0] be;
    } req_t;

    req_t req_q;
    logic we_r;

    // Only the strobe is reset; mask, address and data registers have no clear
    always_ff @(posedge clk) begin
        if (rst) we_r <= 1'b0;
        else     we_r <= wr_en;
    end

    always_ff @(posedge clk) begin
        req_q <= '{addr: addr, data: wdata, be: byte_en};
    end

    assign we_q   = we_r;
    assign addr_q = req_q.addr;
    assign data_q = req_q.data;
    assign be_q   = req_q.be;

endmodule

// File: rtl/ber_lane_col.sv
`timescale 1ns/1ps
module ber_lane_col
    import ber_pkg::*;
#(
    parameter int unsigned LANE_W = 9,
    parameter int unsigned AW     = 6,
    parameter mask_pol_e   POLICY = MASK_KEEP,
    parameter logic [8:0]  FILL   = 9'h0A5
) (
    input  logic              clk,
    input  logic              we_q,
    input  logic              en_q,
    input  logic [AW-1:0]     addr_q,
    input  logic [LANE_W-1:0] din_q,
    output logic [LANE_W-1:0] dout
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [LANE_W-1:0] col [DEPTH];
    logic [LANE_W-1:0] held;
    logic              lane_wr;

    assign lane_wr = we_q & en_q;

    always_ff @(posedge clk) begin
        if (lane_wr) col[addr_q] <= din_q;
    end

    assign held = col[addr_q];

    generate
        if (POLICY == MASK_FILL) begin : g_fill
            always_comb begin
                if (lane_wr)   dout = din_q;
                else if (we_q) dout = FILL[LANE_W-1:0];
                else           dout = held;
            end
        end else begin : g_keep
            always_comb begin
                if (lane_wr) dout = din_q;
                else         dout = held;
            end
        end
    endgenerate

endmodule

// File: rtl/ber_ram.sv
`timescale 1ns/1ps
module ber_ram
    import ber_pkg::*;
#(
    parameter int unsigned LANES    = 2,
    parameter int unsigned LANE_W   = 9,
    parameter int unsigned AW       = 6,
    parameter mask_pol_e   POLICY   = MASK_KEEP,
    parameter logic [8:0]  FILL_PAT = 9'h0A5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [AW-1:0]            addr,
    input  logic [LANES*LANE_W-1:0]  wdata,
    input  logic [LANES-1:0]         byte_en,
    output logic [LANES*LANE_W-1:0]  rdata
);

    localparam int unsigned DW = word_width(LANES, LANE_W);

    logic             we_q;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    data_q;
    logic [LANES-1:0] be_q;

    ber_req_reg #(.LANES(LANES), .DW(DW), .AW(AW)) u_req (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .byte_en (byte_en),
        .we_q    (we_q),
        .addr_q  (addr_q),
        .data_q  (data_q),
        .be_q    (be_q)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        ber_lane_col #(
            .LANE_W (LANE_W),
            .AW     (AW),
            .POLICY (POLICY),
            .FILL   (FILL_PAT)
        ) u_col (
            .clk    (clk),
            .we_q   (we_q),
            .en_q   (be_q[i]),
            .addr_q (addr_q),
            .din_q  (data_q[i*LANE_W +: LANE_W]),
            .dout   (rdata[i*LANE_W +: LANE_W])
        );
    end

endmodule

// File: rtl/ber_ram_chk.sv
`timescale 1ns/1ps
module ber_ram_chk
    import ber_pkg::*;
#(
    parameter int unsigned LANES    = 2,
    parameter int unsigned LANE_W   = 9,
    parameter int unsigned AW       = 6,
    parameter mask_pol_e   POLICY   = MASK_KEEP,
    parameter logic [8:0]  FILL_PAT = 9'h0A5
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    wr_en,
    input logic [AW-1:0]           addr,
    input logic [LANES*LANE_W-1:0] wdata,
    input logic [LANES-1:0]        byte_en,
    input logic [LANES*LANE_W-1:0] rdata
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // R6: enabled lane passes new data through in the write cycle
        assert_write_through_R6: assert property (@(posedge clk) disable iff (rst)
            ($past(wr_en) && !$past(rst) && $past(byte_en[i]))
            |-> rdata[i*LANE_W +: LANE_W] == $past(wdata[i*LANE_W +: LANE_W]));

        // R4: enabled lane is stored and read back on the next idle read
        assert_lane_commit_R4: assert property (@(posedge clk) disable iff (rst)
            ($past(wr_en, 2) && !$past(rst, 2) && $past(byte_en[i], 2)
             && !$past(wr_en) && !$past(rst) && $past(addr) == $past(addr, 2))
            |-> rdata[i*LANE_W +: LANE_W] == $past(wdata[i*LANE_W +: LANE_W], 2));

        if (POLICY == MASK_FILL) begin : g_fill
            // R8: masked lane shows the filler during the write cycle
            assert_masked_fill_R8: assert property (@(posedge clk) disable iff (rst)
                ($past(wr_en) && !$past(rst) && !$past(byte_en[i]))
                |-> rdata[i*LANE_W +: LANE_W] == FILL_PAT[LANE_W-1:0]);
        end else begin : g_keep
            // R7/R5: masked lane in the write cycle equals what an idle read shows after
            assert_masked_keep_R7: assert property (@(posedge clk) disable iff (rst)
                ($past(wr_en, 2) && !$past(rst, 2) && !$past(byte_en[i], 2)
                 && !$past(wr_en) && !$past(rst) && $past(addr) == $past(addr, 2))
                |-> rdata[i*LANE_W +: LANE_W] == $past(rdata[i*LANE_W +: LANE_W]));
        end
    end

    // R9: two idle reads of one address return the same word whatever the mask
    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_en) && !$past(rst) && !$past(wr_en, 2) && !$past(rst, 2)
         && $past(addr) == $past(addr, 2))
        |-> $stable(rdata));

endmodule

bind ber_ram ber_ram_chk #(
    .LANES    (LANES),
    .LANE_W   (LANE_W),
    .AW       (AW),
    .POLICY   (POLICY),
    .FILL_PAT (FILL_PAT)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .byte_en (byte_en),
    .rdata   (rdata)
);

// File: tb/sim_ber_ram.sv
`timescale 1ns/1ps
module sim_ber_ram;
    import ber_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [17:0] wd0 = '0;
    logic [31:0] wd1 = '0;
    logic [3:0]  be = '0;
    logic [17:0] rd0;
    logic [31:0] rd1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [17:0] m0 [16];
    logic [31:0] m1 [16];

    always #4 clk = ~clk;   // 125 MHz

    // Two 9-bit lanes, keep policy
    ber_ram #(.LANES(2), .LANE_W(9), .AW(4), .POLICY(MASK_KEEP), .FILL_PAT(9'h0A5)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wd0), .byte_en(be[1:0]), .rdata(rd0));

    // Four 8-bit lanes, fill policy with 8'h5A
    ber_ram #(.LANES(4), .LANE_W(8), .AW(4), .POLICY(MASK_FILL), .FILL_PAT(9'h05A)) u1 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wd1), .byte_en(be), .rdata(rd1));

    task automatic check(input string tag, input string who,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", tag, who, act, exp);
        end
    endtask

    // One clock: drive, let the edge pass, compare at the falling edge, update the model
    task automatic step(input logic we, input logic [3:0] a, input logic [17:0] d0,
                        input logic [31:0] d1, input logic [3:0] m, input string tag);
        logic        eff;
        logic [17:0] e0;
        logic [31:0] e1;
        wr_en = we; addr = a; wd0 = d0; wd1 = d1; be = m;
        @(posedge clk);
        eff = we && !rst;
        @(negedge clk);
        for (int i = 0; i < 2; i++)
            e0[i*9 +: 9] = (eff && m[i]) ? d0[i*9 +: 9] : m0[a][i*9 +: 9];
        for (int i = 0; i < 4; i++)
            e1[i*8 +: 8] = (eff && m[i]) ? d1[i*8 +: 8]
                         : (eff ? 8'h5A : m1[a][i*8 +: 8]);
        if (!$isunknown(e0)) check(tag, "u0", {14'b0, rd0}, {14'b0, e0});
        if (!$isunknown(e1)) check(tag, "u1", rd1, e1);
        if (eff) begin
            for (int i = 0; i < 2; i++) if (m[i]) m0[a][i*9 +: 9] = d0[i*9 +: 9];
            for (int i = 0; i < 4; i++) if (m[i]) m1[a][i*8 +: 8] = d1[i*8 +: 8];
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin m0[i] = 'x; m1[i] = 'x; end
        // reset cycles: output unknown memory, so only known values are compared
        step(1'b0, 4'd0, '0, '0, 4'h0, "R10");
        step(1'b0, 4'd0, '0, '0, 4'h0, "R10");
        rst = 1'b0;

        // R11: full mask preload of every word, write-through checked
        for (int i = 0; i < 16; i++)
            step(1'b1, 4'(i), 18'(i * 18'h0_2469), 32'h1357_0000 + 32'(i * 32'h111),
                 4'hF, "R11");
        // R4: read back all words
        for (int i = 0; i < 16; i++)
            step(1'b0, 4'(i), '0, '0, 4'(i), "R4");

        // R2/R7/R8: location 3 of all ones, then upper-lane-only write
        step(1'b1, 4'd3, 18'h3FFFF, 32'hFFFF_FFFF, 4'hF, "R11");
        step(1'b1, 4'd3, {9'h0AB, 9'h0CD}, 32'hABCD_1234, 4'b0010, "R2");
        step(1'b0, 4'd3, '0, '0, 4'hF, "R5");
        // R2: lower lane only
        step(1'b1, 4'd3, 18'h3FFFF, 32'hFFFF_FFFF, 4'hF, "R11");
        step(1'b1, 4'd3, {9'h0AB, 9'h0CD}, 32'hABCD_1234, 4'b0001, "R7");
        step(1'b0, 4'd3, '0, '0, 4'h0, "R2");
        // R8: fill shows on three masked lanes of u1
        step(1'b1, 4'd4, 18'h1_5555, 32'h0102_0304, 4'b0100, "R8");
        step(1'b0, 4'd4, '0, '0, 4'h0, "R8");

        // R3: parity bit (lane bit 8) carried by a single mask bit
        step(1'b1, 4'd5, 18'h0, 32'h0, 4'hF, "R3");
        step(1'b1, 4'd5, {9'h100, 9'h1FF}, 32'h8080_8080, 4'b0001, "R3");
        step(1'b0, 4'd5, '0, '0, 4'h0, "R3");
        step(1'b1, 4'd5, {9'h155, 9'h000}, 32'h0, 4'b0010, "R3");
        step(1'b0, 4'd5, '0, '0, 4'h0, "R3");

        // R5: all-zero mask write leaves the word unchanged
        step(1'b1, 4'd6, 18'h2_AAAA, 32'hDEAD_BEEF, 4'h0, "R5");
        step(1'b0, 4'd6, '0, '0, 4'h0, "R5");

        // R9: idle cycles with changing mask do nothing
        for (int i = 0; i < 8; i++)
            step(1'b0, 4'd6, 18'($urandom), $urandom, 4'($urandom), "R9");
        step(1'b0, 4'd3, '0, '0, 4'h0, "R9");

        // R10: write requested during reset is dropped, contents kept
        rst = 1'b1;
        step(1'b1, 4'd7, 18'h0_1111, 32'h2222_3333, 4'hF, "R10");
        rst = 1'b0;
        step(1'b0, 4'd7, '0, '0, 4'h0, "R10");
        step(1'b1, 4'd8, 18'h3_0F0F, 32'h0F0F_0F0F, 4'b1010, "R6");

        // R1/R6: random traffic
        for (int i = 0; i < 600; i++)
            step(1'($urandom), 4'($urandom), 18'($urandom), $urandom,
                 4'($urandom), "R1");
        step(1'b0, 4'd0, '0, '0, 4'h0, "R4");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule